// File: doc/BRIEF.md
# Cascadable Reload Timer Trio with Square-Wave Output

The block holds three 8-bit down-counters. Each counter has its own reload register and its own interrupt request flag. Every counter advances only on a one-cycle count pulse. The first counter takes either the divided main-clock tick or the subclock tick. The second and third counters each take either the divided tick or the underflow of the counter before them. This lets them be chained into a longer prescaler. An underflow event lasts a single cycle. It acts as a count enable in the same clock domain, so a chain of counters advances in the same edge.

A toggle flip-flop flips on every underflow of the second counter and can drive the square-wave output pin. When the output is disabled, the pin carries an ordinary port level. Software reaches everything through a plain 8-bit register bus. Writes take one cycle and read data is combinational, so no handshake is needed. The tick inputs are produced outside the block.

Top module: `cascade_timer_unit`

## Requirements
- R1: On each cycle where a counter's selected count pulse is high, a nonzero counter value decreases by one. Without a pulse or a write, the value holds.
- R2: A pulse that arrives while a counter is at 0 is an underflow. It loads the counter from its reload register.
- R3: Each underflow sets interrupt flag bit i (counter 0 to bit 0, counter 1 to bit 1, counter 2 to bit 2) at address 4. Writing 1 to a bit at address 4 clears it. An underflow in the same cycle wins over the clear.
- R4: Mode register (address 3) source bits are as follows. Bit 0 selects the count source for counter 0: 0 is the divided tick, 1 is the subclock tick. Bit 1 selects it for counter 1: 0 is the divided tick, 1 is counter 0's underflow. Bit 2 selects it for counter 2: 0 is the divided tick, 1 is counter 1's underflow.
- R5: When mode bit 3 is 0, a write to counter 1 loads both its reload register and its counter. When bit 3 is 1, the write loads only the reload register. Writes to counters 0 and 2 always load both.
- R6: Addresses 0, 1 and 2 write the timers and read back the live counter values. Address 3 reads back the mode register. Address 4 reads the flags. Every other address reads 0.
- R7: When mode bit 4 is 1, the pin shows the toggle flip-flop, which inverts on every underflow of counter 1. When bit 4 is 0, the pin shows `port_out_val`.
- R8: Every write to the mode register sets the toggle flip-flop to the value of written bit 5.
- R9: After reset, all counters and reload registers read FF, the mode and the flags read 0, and the toggle flip-flop is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_tick | input | 1 | One-cycle pulse from the divided main clock |
| sub_tick | input | 1 | One-cycle pulse from the subclock |
| port_out_val | input | 1 | Pin level used while the toggle output is disabled |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 3 | Interrupt request flags, one per counter |
| toggle_pin | output | 1 | Square-wave or port output |

## Verification
The bench goes after several corner cases. It runs a counter through zero, where a design that reloads one pulse early or late shows a wrong count and a wrong flag. It chains counters, where a cascade that lags by a register cycle or takes the wrong source leaves the downstream count off. It writes counter 1 in the latch-only mode and then checks that the next reload uses the new value while the running count stays untouched. It checks the pin across toggles, start-level presets and the switch to the port level, where a missed preset or a toggle while disabled shows up as a wrong level.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int NUM_TMR   = 3;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int ADDR_MODE = 3;
  localparam int ADDR_IRQ  = 4;
  localparam int LATCH_CTL_IDX = 1;
  localparam int TOGGLE_SRC_IDX = 1;

  typedef struct packed {
    logic [1:0] spare;
    logic       start_hi;
    logic       out_en;
    logic       t2_latch_only;
    logic       t3_chain;
    logic       t2_chain;
    logic       t1_sub;
  } mode_t;
endpackage

// File: rtl/reload_timer8.sv
module reload_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_latch_i,
  input  logic         load_cnt_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] latch_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, latch_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf_o    = tick_i && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else if (load_latch_i) latch_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else if (load_cnt_i) cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= at_zero ? latch_q : cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/toggle_out.sv
module toggle_out (
  input  logic clk,
  input  logic rst_n,
  input  logic preset_i,
  input  logic preset_lvl_i,
  input  logic toggle_i,
  input  logic en_i,
  input  logic port_i,
  output logic pin_o
);
  logic tff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tff_q <= 1'b0;
    else if (preset_i) tff_q <= preset_lvl_i;
    else if (toggle_i) tff_q <= ~tff_q;
  end

  assign pin_o = en_i ? tff_q : port_i;
endmodule

// File: rtl/cascade_timer_unit.sv
module cascade_timer_unit
  import ctu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_tick,
  input  logic              sub_tick,
  input  logic              port_out_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_TMR-1:0] irq,
  output logic              toggle_pin
);
  mode_t mode_q;
  logic [NUM_TMR-1:0]             tick, uf, wr_tmr, chain_sel;
  logic [NUM_TMR-1:0][DATA_W-1:0] cnt, latch;
  logic [NUM_TMR-1:0]             irq_q;
  logic                           mode_wr, irq_wr;

  assign mode_wr = wr_en && (addr == ADDR_W'(ADDR_MODE));
  assign irq_wr  = wr_en && (addr == ADDR_W'(ADDR_IRQ));
  assign chain_sel = {mode_q.t3_chain, mode_q.t2_chain, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_t'(wdata);
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic load_cnt;
    assign wr_tmr[i] = wr_en && (addr == ADDR_W'(i));
    if (i == 0) begin : g_first
      assign tick[i] = mode_q.t1_sub ? sub_tick : div_tick;
    end else begin : g_chained
      assign tick[i] = chain_sel[i] ? uf[i-1] : div_tick;
    end
    if (i == LATCH_CTL_IDX) begin : g_wctl
      assign load_cnt = wr_tmr[i] && !mode_q.t2_latch_only;
    end else begin : g_plain
      assign load_cnt = wr_tmr[i];
    end
    reload_timer8 #(.W(DATA_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick[i]),
      .load_latch_i(wr_tmr[i]), .load_cnt_i(load_cnt), .wdata_i(wdata),
      .cnt_o(cnt[i]), .latch_o(latch[i]), .uf_o(uf[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else if (irq_wr) irq_q <= (irq_q & ~wdata[NUM_TMR-1:0]) | uf;
    else irq_q <= irq_q | uf;
  end
  assign irq = irq_q;

  toggle_out u_tog (
    .clk(clk), .rst_n(rst_n), .preset_i(mode_wr), .preset_lvl_i(wdata[5]),
    .toggle_i(uf[TOGGLE_SRC_IDX]), .en_i(mode_q.out_en), .port_i(port_out_val),
    .pin_o(toggle_pin)
  );

  always_comb begin
    rdata = '0;
    if (addr < ADDR_W'(NUM_TMR)) rdata = cnt[addr[1:0]];
    else if (addr == ADDR_W'(ADDR_MODE)) rdata = mode_q;
    else if (addr == ADDR_W'(ADDR_IRQ)) rdata = DATA_W'(irq_q);
  end
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker
  import ctu_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_TMR-1:0]             tick,
  input logic [NUM_TMR-1:0]             uf,
  input logic [NUM_TMR-1:0]             wr_tmr,
  input logic [NUM_TMR-1:0][DATA_W-1:0] cnt,
  input logic [NUM_TMR-1:0][DATA_W-1:0] latch,
  input logic [NUM_TMR-1:0]             irq,
  input logic                           mode_wr,
  input logic [DATA_W-1:0]              wdata,
  input logic                           out_en,
  input logic                           pin
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] && cnt[i] != '0 && !wr_tmr[i] |=> cnt[i] == DATA_W'($past(cnt[i]) - 1'b1)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[i] && !wr_tmr[i] |=> $stable(cnt[i])); // R1
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      uf[i] && !wr_tmr[i] |=> cnt[i] == $past(latch[i])); // R2
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      uf[i] |=> irq[i]); // R3
  end

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    uf[TOGGLE_SRC_IDX] && out_en && !mode_wr |=> pin != $past(pin)); // R7
  AST_PRESET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && wdata[4] |=> pin == $past(wdata[5])); // R8
endmodule

bind cascade_timer_unit ctu_checker u_ctu_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .uf(uf), .wr_tmr(wr_tmr),
  .cnt(cnt), .latch(latch), .irq(irq), .mode_wr(mode_wr), .wdata(wdata),
  .out_en(mode_q.out_en), .pin(toggle_pin)
);

// File: tb/tb_cascade_timer_unit.sv
module tb_cascade_timer_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_WR = 3'd0, OP_CHK = 3'd1, OP_DIV = 3'd2,
                         OP_SUB = 3'd3, OP_PIN = 3'd4, OP_PORT = 3'd5;
  localparam int NV = 61;
  // {requirement, op, addr, data}
  localparam logic [17:0] VEC [NV] = '{
    // R9 reset values
    {4'd9,OP_CHK,3'd0,8'hFF}, {4'd9,OP_CHK,3'd2,8'hFF}, {4'd9,OP_CHK,3'd3,8'h00},
    {4'd9,OP_CHK,3'd4,8'h00}, {4'd9,OP_PIN,3'd0,8'h00},
    // R6 write loads counter, unused address reads 0
    {4'd6,OP_WR,3'd0,8'h05}, {4'd6,OP_CHK,3'd0,8'h05}, {4'd6,OP_CHK,3'd7,8'h00},
    // R1 down count
    {4'd1,OP_DIV,3'd0,8'd3}, {4'd1,OP_CHK,3'd0,8'h02}, {4'd1,OP_CHK,3'd1,8'hFC},
    {4'd1,OP_DIV,3'd0,8'd2},
    // R2 reload and R3 flags
    {4'd2,OP_CHK,3'd0,8'h00}, {4'd3,OP_CHK,3'd4,8'h00}, {4'd2,OP_DIV,3'd0,8'd1},
    {4'd2,OP_CHK,3'd0,8'h05}, {4'd3,OP_CHK,3'd4,8'h01}, {4'd3,OP_WR,3'd4,8'h01},
    {4'd3,OP_CHK,3'd4,8'h00},
    // R4 cascade counter 1 on counter 0
    {4'd4,OP_WR,3'd3,8'h02}, {4'd4,OP_WR,3'd0,8'h01}, {4'd4,OP_WR,3'd1,8'h02},
    {4'd4,OP_DIV,3'd0,8'd2}, {4'd4,OP_CHK,3'd1,8'h01}, {4'd4,OP_CHK,3'd2,8'hF7},
    {4'd4,OP_DIV,3'd0,8'd4}, {4'd4,OP_CHK,3'd1,8'h02}, {4'd3,OP_CHK,3'd4,8'h03},
    // R5 latch-only write
    {4'd5,OP_WR,3'd3,8'h0A}, {4'd5,OP_WR,3'd1,8'h07}, {4'd5,OP_CHK,3'd1,8'h02},
    {4'd5,OP_DIV,3'd0,8'd4}, {4'd5,OP_CHK,3'd1,8'h00}, {4'd5,OP_DIV,3'd0,8'd2},
    {4'd5,OP_CHK,3'd1,8'h07},
    // R4 subclock source
    {4'd4,OP_WR,3'd3,8'h01}, {4'd4,OP_WR,3'd0,8'h09}, {4'd4,OP_DIV,3'd0,8'd3},
    {4'd4,OP_CHK,3'd0,8'h09}, {4'd4,OP_SUB,3'd0,8'd2}, {4'd4,OP_CHK,3'd0,8'h07},
    // R8 preset and R7 toggling
    {4'd8,OP_WR,3'd3,8'h30}, {4'd8,OP_PIN,3'd0,8'h01}, {4'd7,OP_WR,3'd1,8'h01},
    {4'd7,OP_DIV,3'd0,8'd1}, {4'd7,OP_PIN,3'd0,8'h01}, {4'd7,OP_DIV,3'd0,8'd1},
    {4'd7,OP_PIN,3'd0,8'h00}, {4'd7,OP_DIV,3'd0,8'd2}, {4'd7,OP_PIN,3'd0,8'h01},
    {4'd8,OP_WR,3'd3,8'h10}, {4'd8,OP_PIN,3'd0,8'h00}, {4'd7,OP_PORT,3'd0,8'h01},
    {4'd7,OP_PIN,3'd0,8'h00}, {4'd7,OP_WR,3'd3,8'h00}, {4'd7,OP_PIN,3'd0,8'h01},
    // R4 cascade counter 2 on counter 1
    {4'd4,OP_WR,3'd3,8'h04}, {4'd4,OP_WR,3'd1,8'h00}, {4'd4,OP_WR,3'd2,8'h03},
    {4'd4,OP_DIV,3'd0,8'd2}, {4'd4,OP_CHK,3'd2,8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic div_tick = 1'b0, sub_tick = 1'b0, port_out_val = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] irq;
  logic toggle_pin;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .sub_tick(sub_tick),
    .port_out_val(port_out_val), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .toggle_pin(toggle_pin)
  );

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input bit use_sub, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (use_sub) sub_tick = 1'b1; else div_tick = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0; div_tick = 1'b0;
    end
  endtask

  task automatic rd_check(input int req, input logic [2:0] a, input logic [7:0] exp);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][13:11])
        OP_WR:   wr(VEC[v][10:8], VEC[v][7:0]);
        OP_CHK:  rd_check(int'(VEC[v][17:14]), VEC[v][10:8], VEC[v][7:0]);
        OP_DIV:  pulse(1'b0, int'(VEC[v][7:0]));
        OP_SUB:  pulse(1'b1, int'(VEC[v][7:0]));
        OP_PIN:  begin #1; check(int'(VEC[v][17:14]), {7'd0, toggle_pin}, VEC[v][7:0]); end
        default: port_out_val = VEC[v][0];
      endcase
    end
    // R9 reset in the middle of a run: counters FF, mode and flags clear, pin follows port
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_check(9, 3'd1, 8'hFF);
    rd_check(9, 3'd3, 8'h00);
    rd_check(9, 3'd4, 8'h00);
    #1; check(9, {7'd0, toggle_pin}, 8'h01);
    // R5 the latch-only bit leaves counters 0 and 2 writing both
    wr(3'd3, 8'h08);
    wr(3'd0, 8'h11);
    rd_check(5, 3'd0, 8'h11);
    wr(3'd2, 8'h22);
    rd_check(5, 3'd2, 8'h22);
    // R3 set wins over clear in the same cycle: counter 1 latch 0 underflows every tick
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h00);
    @(negedge clk); wr_en = 1'b1; addr = 3'd4; wdata = 8'h02; div_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; div_tick = 1'b0;
    rd_check(3, 3'd4, 8'h02);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule